// File: doc/BRIEF.md
# Linear CCD Drive Timing Generator

This block derives every digital drive waveform for a three-colour linear CCD from a single system clock. Each colour reads out through a pair of charge registers, one for odd and one for even photosites. The outputs are the transfer gate pulses for the three colours, the two complementary shift clocks, the last-stage clock, the reset gate clock and the clamp clock. It also emits a line-start marker and a per-shift-cycle pixel strobe that a downstream sampler uses to time its conversions.

Every line has the same sequence. A guard interval freezes the shift clocks. Then all transfer gates pulse together, a second guard follows, and the readout runs a fixed number of shift cycles. An idle fill pads the line out to the programmed period. Guard, gate width, clamp margin and period are counted in system-clock ticks. They are captured from the configuration inputs while the block is stopped and again on the last tick of every line, so a change made during a line takes effect at the next line start. The clamp style input picks one of two waveforms. In per-pixel clamping, the reset and clamp clocks pulse every pixel period, including during the transfer. In per-line clamping, the reset gate is held high through the transfer and the clamp clock drops only in a window around it. A period too short for the sequence is stretched to the minimum and flagged.

Top module: `ccd_timing_gen`

## Requirements
- R1: While stopped (`run_en` low at the previous edge), the outputs are: all gates low, `phi1` high, `phi2` low, `phi1_last` high, `rst_gate` low, `line_start` low and `pix_strobe` low. `clamp` is high when the captured style is per-line (`cfg_line_clamp`=1) and low when it is per-pixel (0).
- R2: The first line starts one cycle after `run_en` is seen high. Tick 0 of every line has `line_start` high. A line lasts `cfg_period` ticks when that value is at least the minimum of 2·guard + gate width + SHIFTS·PIX_TICKS.
- R3: All three transfer gates rise together at tick `guard` and stay high for exactly `cfg_tg_width` ticks.
- R4: The shift clocks are frozen with `phi1` high and `phi2` low from tick 0 until tick 2·guard + gate width, which covers both guard intervals around the gate. They stay frozen after readout ends.
- R5: Readout is SHIFTS cycles of PIX_TICKS ticks each. Within a cycle, `phi1` is high for the first PIX_TICKS/2 ticks and `phi2` for the rest. `phi1_last` always equals `phi1`.
- R6: `pix_strobe` is high on the last tick of each readout shift cycle only, which gives exactly SHIFTS strobes per line.
- R7: In per-pixel clamping, `rst_gate` is high on phase 0 of every pixel period and `clamp` is high on phase 1, also during the guards and the gate. The pixel phase counts from 0 at tick 0, restarts at 0 when readout begins, and then runs on through the fill.
- R8: In per-line clamping, `rst_gate` is high for the whole gate interval and otherwise pulses as in R7. `clamp` is low from tick max(0, guard − margin) up to tick min(guard + width + margin, 2·guard + width), and high at every other tick of the line.
- R9: If `cfg_period` is below the minimum, that line lasts exactly the minimum and `cfg_short` is high. Otherwise `cfg_short` is low.
- R10: A configuration change made during a line leaves that line unchanged. It applies from the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run the line sequence while high |
| cfg_line_clamp | input | 1 | 1 = per-line clamping, 0 = per-pixel clamping |
| cfg_guard | input | 24 | Guard ticks on each side of the transfer gate |
| cfg_tg_width | input | 24 | Transfer gate high ticks |
| cfg_clamp_margin | input | 24 | Clamp low margin around the gate, per-line mode |
| cfg_period | input | 24 | Requested line period in ticks |
| tg_gate | output | 3 | Transfer gates, one per colour |
| phi1 | output | 1 | Shift clock phase 1 |
| phi2 | output | 1 | Shift clock phase 2 |
| phi1_last | output | 1 | Last-stage shift clock |
| rst_gate | output | 1 | Reset gate clock |
| clamp | output | 1 | Clamp clock |
| line_start | output | 1 | High on tick 0 of each line |
| pix_strobe | output | 1 | High on the last tick of each readout shift cycle |
| cfg_short | output | 1 | Current line period was stretched to the minimum |

## Verification
The assertions take for granted that PIX_TICKS is even and at least 4, so that phase 1 falls inside the `phi1` half and the strobe falls inside the `phi2` half. They also assume the captured guard is non-zero, so the transfer gate never shares a tick with readout. The stimulus uses guards of 3 to 5 ticks with PIX_TICKS of 4. It changes the clamp style only while a line is running, so the switch always lands on a line start with the pixel phase at 0. One configuration drives the clamp margin past the guard on purpose, to exercise the clipping of the clamp window.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
  parameter int unsigned TICK_W = 24;

  typedef logic [TICK_W-1:0] tick_t;

  typedef enum logic {
    CLAMP_PIXEL = 1'b0,
    CLAMP_LINE  = 1'b1
  } clamp_style_e;

  // Tick boundaries of one line, fixed at line start
  typedef struct packed {
    tick_t        gate_on;
    tick_t        gate_off;
    tick_t        read_on;
    tick_t        read_off;
    tick_t        win_lo;
    tick_t        win_hi;
    tick_t        period;
    clamp_style_e style;
  } line_plan_t;
endpackage

// File: rtl/ccd_tg_cfg.sv
module ccd_tg_cfg
  import ccd_tg_pkg::*;
#(
  parameter int unsigned SHIFTS    = 3719,
  parameter int unsigned PIX_TICKS = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       req_line_clamp,
  input  tick_t      req_guard,
  input  tick_t      req_width,
  input  tick_t      req_margin,
  input  tick_t      req_period,
  output line_plan_t plan_q,
  output logic       short_q
);
  localparam tick_t READ_TICKS = tick_t'(SHIFTS * PIX_TICKS);

  line_plan_t plan_d;
  logic       short_d;
  tick_t      late_edge;

  always_comb begin
    plan_d.gate_on  = req_guard;
    plan_d.gate_off = req_guard + req_width;
    plan_d.read_on  = plan_d.gate_off + req_guard;
    plan_d.read_off = plan_d.read_on + READ_TICKS;
    plan_d.win_lo   = (req_margin > req_guard) ? '0 : req_guard - req_margin;
    late_edge       = plan_d.gate_off + req_margin;
    plan_d.win_hi   = (late_edge > plan_d.read_on) ? plan_d.read_on : late_edge;
    short_d         = req_period < plan_d.read_off;
    plan_d.period   = short_d ? plan_d.read_off : req_period;
    plan_d.style    = req_line_clamp ? CLAMP_LINE : CLAMP_PIXEL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plan_q  <= '0;
      short_q <= 1'b0;
    end else if (load) begin
      plan_q  <= plan_d;
      short_q <= short_d;
    end
  end
endmodule

// File: rtl/ccd_tg_seq.sv
module ccd_tg_seq
  import ccd_tg_pkg::*;
#(
  parameter int unsigned PIX_TICKS = 14,
  localparam int unsigned PIX_W    = $clog2(PIX_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  line_plan_t       plan,
  output logic             running,
  output logic [PIX_W-1:0] pix,
  output logic             load,
  output logic             at_start,
  output logic             in_gate,
  output logic             in_read,
  output logic             in_win
);
  localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(PIX_TICKS - 1);

  tick_t cnt;
  tick_t cnt_inc;
  logic  wrap;

  assign cnt_inc  = cnt + 1'b1;
  assign wrap     = running && (cnt_inc == plan.period);
  assign load     = !running || wrap;
  assign at_start = running && (cnt == '0);
  assign in_gate  = (cnt >= plan.gate_on) && (cnt < plan.gate_off);
  assign in_read  = (cnt >= plan.read_on) && (cnt < plan.read_off);
  assign in_win   = (cnt >= plan.win_lo)  && (cnt < plan.win_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      pix     <= '0;
    end else begin
      running <= run_en;
      if (load) begin
        cnt <= '0;
        pix <= '0;
      end else begin
        cnt <= cnt_inc;
        pix <= ((cnt_inc == plan.read_on) || (pix == PIX_LAST)) ? '0 : pix + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccd_tg_drv.sv
module ccd_tg_drv
  import ccd_tg_pkg::*;
#(
  parameter int unsigned PIX_TICKS = 14,
  parameter int unsigned N_COLOUR  = 3,
  localparam int unsigned PIX_W    = $clog2(PIX_TICKS)
) (
  input  logic                running,
  input  clamp_style_e        style,
  input  logic [PIX_W-1:0]    pix,
  input  logic                at_start,
  input  logic                in_gate,
  input  logic                in_read,
  input  logic                in_win,
  output logic [N_COLOUR-1:0] gates,
  output logic                phi1,
  output logic                phi2,
  output logic                phi1_last,
  output logic                rst_gate,
  output logic                clamp,
  output logic                line_start,
  output logic                pix_strobe
);
  localparam logic [PIX_W-1:0] HALF     = PIX_W'(PIX_TICKS / 2);
  localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(PIX_TICKS - 1);

  logic gate_on;
  logic first_half;

  assign gate_on    = running && in_gate;
  assign first_half = pix < HALF;

  for (genvar c = 0; c < N_COLOUR; c++) begin : g_colour
    assign gates[c] = gate_on;
  end

  always_comb begin
    phi1       = 1'b1;
    phi2       = 1'b0;
    rst_gate   = 1'b0;
    clamp      = (style == CLAMP_LINE);
    line_start = 1'b0;
    pix_strobe = 1'b0;
    if (running) begin
      line_start = at_start;
      if (in_read) begin
        phi1       = first_half;
        phi2       = !first_half;
        pix_strobe = (pix == PIX_LAST);
      end
      if (style == CLAMP_LINE) begin
        rst_gate = in_gate || (pix == '0);
        clamp    = !in_win;
      end else begin
        rst_gate = (pix == '0);
        clamp    = (pix == PIX_W'(1));
      end
    end
  end

  assign phi1_last = phi1;
endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_tg_pkg::*;
#(
  parameter int unsigned SHIFTS    = 3719,
  parameter int unsigned PIX_TICKS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              cfg_line_clamp,
  input  logic [TICK_W-1:0] cfg_guard,
  input  logic [TICK_W-1:0] cfg_tg_width,
  input  logic [TICK_W-1:0] cfg_clamp_margin,
  input  logic [TICK_W-1:0] cfg_period,
  output logic [2:0]        tg_gate,
  output logic              phi1,
  output logic              phi2,
  output logic              phi1_last,
  output logic              rst_gate,
  output logic              clamp,
  output logic              line_start,
  output logic              pix_strobe,
  output logic              cfg_short
);
  localparam int unsigned PIX_W = $clog2(PIX_TICKS);

  line_plan_t       plan;
  logic             running;
  logic [PIX_W-1:0] pix;
  logic             load;
  logic             at_start;
  logic             in_gate;
  logic             in_read;
  logic             in_win;
  logic             mode_line;

  assign mode_line = (plan.style == CLAMP_LINE);

  ccd_tg_cfg #(.SHIFTS(SHIFTS), .PIX_TICKS(PIX_TICKS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .req_line_clamp(cfg_line_clamp), .req_guard(cfg_guard),
    .req_width(cfg_tg_width), .req_margin(cfg_clamp_margin),
    .req_period(cfg_period), .plan_q(plan), .short_q(cfg_short)
  );

  ccd_tg_seq #(.PIX_TICKS(PIX_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .plan(plan),
    .running(running), .pix(pix), .load(load), .at_start(at_start),
    .in_gate(in_gate), .in_read(in_read), .in_win(in_win)
  );

  ccd_tg_drv #(.PIX_TICKS(PIX_TICKS), .N_COLOUR(3)) u_drv (
    .running(running), .style(plan.style), .pix(pix), .at_start(at_start),
    .in_gate(in_gate), .in_read(in_read), .in_win(in_win),
    .gates(tg_gate), .phi1(phi1), .phi2(phi2), .phi1_last(phi1_last),
    .rst_gate(rst_gate), .clamp(clamp), .line_start(line_start),
    .pix_strobe(pix_strobe)
  );
endmodule

// File: rtl/ccd_tg_chk.sv
module ccd_tg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] tg_gate,
  input logic       phi1,
  input logic       phi2,
  input logic       rst_gate,
  input logic       clamp,
  input logic       pix_strobe,
  input logic       mode_line
);
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1 && phi2));

  a_r3_gates_together: assert property (@(posedge clk) disable iff (!rst_n)
    (tg_gate == 3'b000) || (tg_gate == 3'b111));

  a_r4_frozen_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    tg_gate[0] |-> (phi1 && !phi2));

  a_r8_reset_high_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_line && tg_gate[0]) |-> rst_gate);

  a_r8_clamp_low_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_line && tg_gate[0]) |-> !clamp);

  a_r7_clamp_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_line && $rose(clamp)) |-> $past(rst_gate));

  a_r6_strobe_in_readout: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |-> (phi2 && !tg_gate[0]));
endmodule

bind ccd_timing_gen ccd_tg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tg_gate(tg_gate), .phi1(phi1), .phi2(phi2),
  .rst_gate(rst_gate), .clamp(clamp), .pix_strobe(pix_strobe),
  .mode_line(mode_line)
);

// File: tb/tb_ccd_timing_gen.sv
`timescale 1ns/1ps
module tb_ccd_timing_gen;
  localparam int S = 6;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        cfg_line_clamp = 1'b0;
  logic [23:0] cfg_guard = '0, cfg_tg_width = '0, cfg_clamp_margin = '0, cfg_period = '0;
  logic [2:0]  tg_gate;
  logic        phi1, phi2, phi1_last, rst_gate, clamp, line_start, pix_strobe, cfg_short;

  int checks = 0;
  int fails  = 0;
  logic [10:0] expq[$];

  always #2 clk = ~clk;

  ccd_timing_gen #(.SHIFTS(S), .PIX_TICKS(P)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_line_clamp(cfg_line_clamp),
    .cfg_guard(cfg_guard), .cfg_tg_width(cfg_tg_width),
    .cfg_clamp_margin(cfg_clamp_margin), .cfg_period(cfg_period),
    .tg_gate(tg_gate), .phi1(phi1), .phi2(phi2), .phi1_last(phi1_last),
    .rst_gate(rst_gate), .clamp(clamp), .line_start(line_start),
    .pix_strobe(pix_strobe), .cfg_short(cfg_short)
  );

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
    end
  endtask

  // Expected tick vector {short, gates[2:0], phi1, phi2, phi1_last, rst, clamp, start, strobe}
  function automatic logic [10:0] model(int c, int g, int t, int m, int L, bit line);
    int minl = 2*g + t + S*P;
    int b2 = g + t;
    int b3 = 2*g + t;
    bit ingate = (c >= g) && (c < b2);
    bit inread = (c >= b3) && (c < minl);
    int ph = (c < b3) ? c % P : (c - b3) % P;
    int lo = (m > g) ? 0 : g - m;
    int hi = (b2 + m > b3) ? b3 : b2 + m;
    bit p1 = inread ? (ph < P/2) : 1'b1;
    bit p2 = inread ? !(ph < P/2) : 1'b0;
    bit rb = (line && ingate) ? 1'b1 : (ph == 0);
    bit cl = line ? !((c >= lo) && (c < hi)) : (ph == 1);
    bit st = inread && (ph == P-1);
    bit sh = L < minl;
    return {sh, {3{ingate}}, p1, p2, p1, rb, cl, (c == 0), st};
  endfunction

  task automatic push_line(input int g, input int t, input int m, input int L, input bit line);
    int minl = 2*g + t + S*P;
    int len = (L < minl) ? minl : L;
    for (int c = 0; c < len; c++) expq.push_back(model(c, g, t, m, L, line));
  endtask

  task automatic set_cfg(input int g, input int t, input int m, input int L, input bit line);
    cfg_guard = 24'(g); cfg_tg_width = 24'(t); cfg_clamp_margin = 24'(m);
    cfg_period = 24'(L); cfg_line_clamp = line;
  endtask

  task automatic check_idle(input bit line);
    chk(tg_gate, 3'b000, "R1 idle gates");
    chk({2'b0, phi1}, 3'd1, "R1 idle phi1");
    chk({2'b0, phi2}, 3'd0, "R1 idle phi2");
    chk({2'b0, phi1_last}, 3'd1, "R1 idle phi1_last");
    chk({2'b0, rst_gate}, 3'd0, "R1 idle rst_gate");
    chk({2'b0, clamp}, {2'b0, line}, "R1 idle clamp");
    chk({2'b0, line_start}, 3'd0, "R1 idle line_start");
    chk({2'b0, pix_strobe}, 3'd0, "R1 idle strobe");
  endtask

  // Monitor: one expected item per displayed tick
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [10:0] e;
      e = expq.pop_front();
      chk({2'b0, cfg_short}, {2'b0, e[10]}, "R9 short flag");
      chk(tg_gate, e[9:7], "R3 transfer gates");
      chk({2'b0, phi1}, {2'b0, e[6]}, "R4/R5 phi1");
      chk({2'b0, phi2}, {2'b0, e[5]}, "R4/R5 phi2");
      chk({2'b0, phi1_last}, {2'b0, e[4]}, "R5 phi1_last");
      chk({2'b0, rst_gate}, {2'b0, e[3]}, "R7/R8 rst_gate");
      chk({2'b0, clamp}, {2'b0, e[2]}, "R7/R8 clamp");
      chk({2'b0, line_start}, {2'b0, e[1]}, "R2 line_start");
      chk({2'b0, pix_strobe}, {2'b0, e[0]}, "R6 pix_strobe");
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    set_cfg(3, 5, 0, 60, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle(1'b0);                       // R1 per-pixel style
    @(negedge clk) run_en = 1'b1;
    @(posedge clk);
    push_line(3, 5, 0, 60, 1'b0);           // R2, R7
    push_line(3, 5, 0, 60, 1'b0);           // R10: unchanged despite mid-line edit
    push_line(4, 6, 2, 70, 1'b1);           // R8
    push_line(5, 4, 7, 10, 1'b1);           // R9, R8 window clipping
    repeat (70) @(negedge clk);
    set_cfg(4, 6, 2, 70, 1'b1);             // R10 edit inside line 2
    repeat (80) @(negedge clk);
    set_cfg(5, 4, 7, 10, 1'b1);             // R10 edit inside line 3
    wait (expq.size() == 0);
    @(negedge clk) run_en = 1'b0;
    repeat (3) @(negedge clk);
    check_idle(1'b1);                       // R1 per-line style
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule